// File: doc/BRIEF.md
# Framed Serial DAC Input Register

This block is the digital front end of a serial-input digital-to-analog converter. A host drives three wires: an active-low frame select, a serial clock and a serial data line. While the frame select is low, each falling edge of the serial clock shifts one data bit into a 24-bit shift register, most significant bit first. When the 24th falling edge of a frame arrives, the assembled word is transferred into the converter's data register and a one-cycle update strobe is raised.

A fast system clock oversamples all three serial inputs. Each input passes through a two-flop synchronizer, and edges are then detected in the system clock domain. The system clock should run at least four times faster than the serial clock. If the frame select is released before the 24th falling edge, the partial frame is dropped and the data register keeps its old contents. Serial clock edges that arrive after the 24th edge of a frame are ignored until the frame select has gone high and then low again.

The latched word is split into two outputs. The upper eight bits are a control field and the lower sixteen bits are the converter code.

Top module: `sdacFrontEnd`

## Requirements
- R1: After reset, ctrlField and dacCode are zero and updateStb is low.
- R2: Bits are taken on falling serial-clock edges while frameSelN is low, MSB first. After a complete frame, dacCode holds word bits [15:0] and ctrlField holds word bits [23:16], where word bit 23 is the first bit sent.
- R3: Each complete 24-edge frame produces exactly one updateStb pulse, and that pulse lasts exactly one system clock cycle.
- R4: ctrlField and dacCode change only in a cycle where updateStb is high.
- R5: If frameSelN goes high before the 24th falling edge, there is no update pulse and both outputs keep their previous values.
- R6: A falling edge of frameSelN clears the bit count. A full frame that starts straight after an aborted one is therefore received correctly.
- R7: Serial-clock falling edges after the 24th edge of a frame cause neither an update nor an output change until frameSelN rises and falls again.
- R8: Serial-clock falling edges while frameSelN is high do not shift data and do not cause an update.
- R9: updateStb and the new outputs appear after the third rising system-clock edge that follows the 24th serial-clock fall, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSelN | input | 1 | Active-low frame select |
| serClk | input | 1 | Serial clock; data is taken on its falling edge |
| serData | input | 1 | Serial data, MSB first |
| ctrlField | output | 8 | Control field of the last complete frame |
| dacCode | output | 16 | Converter code of the last complete frame |
| updateStb | output | 1 | One-cycle pulse when the data register loads |

## Verification
Every serial edge passes through two synchronizer stages before it is acted on. The strobe and the new word therefore appear after the third rising system-clock edge that follows the input change. A directed frame samples the outputs at the falling system-clock edge after the second rising edge, where nothing may have changed yet, and again after the third, where the pulse and the word must be present. Randomized frames are checked only after at least six idle cycles. A monitor compares the outputs on every falling system-clock edge, so that any change without the strobe is caught in the very cycle it happens. Strobe pulses are counted over each frame, which shows that a frame produced one update or none.

// File: rtl/sdacPkg.sv
package sdacPkg;
  typedef struct packed {
    logic shiftEn;  // take one serial bit into the shift register
    logic load;     // transfer the completed word to the data register
  } sdacStrobes_t;
endpackage

// File: rtl/sdacInSync.sv
module sdacInSync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ[s] <= RESET_VAL;
      end else if (s == 0) begin
        stageQ[s] <= asyncIn;
      end else begin
        stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/sdacCtrl.sv
module sdacCtrl
  import sdacPkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csSync,
  input  logic         sclkSync,
  output sdacStrobes_t strobes
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic             csPrev, sclkPrev;
  logic             armed;
  logic [CNT_W-1:0] bitCnt;
  logic             csFall, sclkFall;

  assign csFall   = csPrev & ~csSync;
  assign sclkFall = sclkPrev & ~sclkSync;

  always_comb begin
    strobes.shiftEn = armed & ~csSync & sclkFall;
    strobes.load    = strobes.shiftEn & (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b1;
      armed    <= 1'b0;
      bitCnt   <= '0;
    end else begin
      csPrev   <= csSync;
      sclkPrev <= sclkSync;
      if (csSync) begin
        armed  <= 1'b0;
        bitCnt <= '0;
      end else if (csFall) begin
        armed  <= 1'b1;
        bitCnt <= '0;
      end else if (strobes.shiftEn) begin
        bitCnt <= bitCnt + 1'b1;
        if (strobes.load) armed <= 1'b0;
      end
    end
  end

  // R7: the count never passes a full word
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(WORD_W));
  // R5, R8: no shift or load while the frame select is high
  a_r5_no_load_released: assert property (@(posedge clk) disable iff (!rstN)
    csSync |-> !strobes.shiftEn && !strobes.load);
  // R3: a load is never followed by another load in the next cycle
  a_r3_single_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> !strobes.load);
  // R7: after a load, the frame stays disarmed until the select is released
  a_r7_disarm_after_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> !armed);
endmodule

// File: rtl/sdacDatapath.sv
module sdacDatapath
  import sdacPkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CODE_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     dataSync,
  input  sdacStrobes_t             strobes,
  output logic [WORD_W-CODE_W-1:0] ctrlField,
  output logic [CODE_W-1:0]        dacCode,
  output logic                     updateStb
);
  localparam int CTRL_W = WORD_W - CODE_W;

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] wordReg;
  logic [WORD_W-1:0] nextWord;

  assign nextWord = {shiftReg[WORD_W-2:0], dataSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      wordReg   <= '0;
      updateStb <= 1'b0;
    end else begin
      updateStb <= strobes.load;
      if (strobes.shiftEn) shiftReg <= nextWord;
      if (strobes.load)    wordReg  <= nextWord;
    end
  end

  assign ctrlField = wordReg[WORD_W-1 -: CTRL_W];
  assign dacCode   = wordReg[CODE_W-1:0];

  // R4: the data register holds unless the strobe is up
  a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !updateStb |-> $stable(wordReg));
  // R3: the strobe is never high for two cycles in a row
  a_r3_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |=> !updateStb);
endmodule

// File: rtl/sdacFrontEnd.sv
module sdacFrontEnd
  import sdacPkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CODE_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameSelN,
  input  logic                     serClk,
  input  logic                     serData,
  output logic [WORD_W-CODE_W-1:0] ctrlField,
  output logic [CODE_W-1:0]        dacCode,
  output logic                     updateStb
);
  logic [2:0]   syncVec;
  sdacStrobes_t strobes;

  sdacInSync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b110)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({frameSelN, serClk, serData}),
    .syncOut(syncVec)
  );

  sdacCtrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .csSync(syncVec[2]), .sclkSync(syncVec[1]),
    .strobes(strobes)
  );

  sdacDatapath #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .dataSync(syncVec[0]), .strobes(strobes),
    .ctrlField(ctrlField), .dacCode(dacCode), .updateStb(updateStb)
  );
endmodule

// File: tb/sdacFrontEnd_bench.sv
module sdacFrontEnd_bench;
  localparam int H = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSelN = 1'b1, serClk = 1'b1, serData = 1'b0;
  logic [7:0]  ctrlField;
  logic [15:0] dacCode;
  logic        updateStb;

  int checks = 0, fails = 0, pulses = 0;
  logic [23:0] expWord = '0;
  logic [23:0] prevOut = '0;
  logic monOn = 1'b0;

  always #2 clk = ~clk;

  sdacFrontEnd u_sdacFrontEnd (
    .clk(clk), .rstN(rstN), .frameSelN(frameSelN), .serClk(serClk),
    .serData(serData), .ctrlField(ctrlField), .dacCode(dacCode),
    .updateStb(updateStb)
  );

  always @(posedge clk) if (rstN && updateStb) pulses++;

  // R4: outputs may only move in a cycle with the strobe high
  always @(negedge clk) begin
    if (monOn && ({ctrlField, dacCode} != prevOut) && !updateStb) begin
      fails++;
      $display("FAIL R4 output changed without strobe: act=%h exp=%h", {ctrlField, dacCode}, prevOut);
    end
    prevOut = {ctrlField, dacCode};
  end

  function automatic logic [15:0] expCode(logic [23:0] w); return w[15:0]; endfunction
  function automatic logic [7:0]  expCtrl(logic [23:0] w); return w[23:16]; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic waitN(int n); repeat (n) @(negedge clk); endtask

  task automatic sendBit(logic b);
    serData = b; waitN(H);
    serClk = 1'b0; waitN(H);
    serClk = 1'b1;
  endtask

  task automatic frame(logic [23:0] w, int nBits, int extra);
    frameSelN = 1'b0; waitN(3);
    for (int i = 0; i < nBits; i++) sendBit(w[23-i]);
    for (int i = 0; i < extra; i++) sendBit(1'($urandom));
    waitN(2); frameSelN = 1'b1; waitN(6);
  endtask

  task automatic checkOut(string req);
    chk({req, " code"}, 32'(dacCode), 32'(expCode(expWord)));
    chk({req, " ctrl"}, 32'(ctrlField), 32'(expCtrl(expWord)));
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int p0;
    logic [23:0] w;
    void'($urandom(32'h5EED_0042));
    waitN(3);
    // R1: reset state
    chk("R1 code", 32'(dacCode), 0);
    chk("R1 ctrl", 32'(ctrlField), 0);
    chk("R1 strobe", 32'(updateStb), 0);
    rstN = 1'b1; waitN(2); monOn = 1'b1;

    // R2, R3: directed full frame
    p0 = pulses; expWord = 24'hA5C3_7E;
    frame(expWord, 24, 0);
    checkOut("R2");
    chk("R3 pulse count", 32'(pulses - p0), 1);

    // R9: exact latency on the 24th edge
    p0 = pulses; w = 24'h3C_1234;
    frameSelN = 1'b0; waitN(3);
    for (int i = 0; i < 23; i++) sendBit(w[23-i]);
    serData = w[0]; waitN(H);
    serClk = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 no strobe after two edges", 32'(updateStb), 0);
    @(posedge clk); @(negedge clk);
    chk("R9 strobe after third edge", 32'(updateStb), 1);
    chk("R9 code with strobe", 32'(dacCode), 32'(w[15:0]));
    @(negedge clk);
    chk("R3 strobe one cycle", 32'(updateStb), 0);
    serClk = 1'b1; waitN(2); frameSelN = 1'b1; waitN(6);
    expWord = w;
    checkOut("R9");

    // R5 then R6: abort, then immediate full frame
    p0 = pulses;
    frame(24'hFFFFFF, 23, 0);
    chk("R5 no pulse on abort", 32'(pulses - p0), 0);
    checkOut("R5");
    p0 = pulses; expWord = 24'h01_8001;
    frame(expWord, 24, 0);
    chk("R6 pulse after abort", 32'(pulses - p0), 1);
    checkOut("R6");

    // R7: extra edges after the 24th
    p0 = pulses; expWord = 24'h5A_F00F;
    frame(expWord, 24, 5);
    chk("R7 single pulse with extra edges", 32'(pulses - p0), 1);
    checkOut("R7");

    // R8: serial clock toggling while deselected
    p0 = pulses;
    for (int i = 0; i < 30; i++) sendBit(1'($urandom));
    waitN(6);
    chk("R8 no pulse while deselected", 32'(pulses - p0), 0);
    checkOut("R8");

    // random mix
    for (int k = 0; k < 80; k++) begin
      int kind;
      kind = int'($urandom % 4);
      w = 24'($urandom);
      p0 = pulses;
      if (kind == 0) begin
        frame(w, int'($urandom % 24), 0);
        chk("R5 random abort pulses", 32'(pulses - p0), 0);
      end else if (kind == 1) begin
        frame(w, 24, 1 + int'($urandom % 4));
        expWord = w;
        chk("R7 random extra pulses", 32'(pulses - p0), 1);
      end else begin
        frame(w, 24, 0);
        expWord = w;
        chk("R2 random pulses", 32'(pulses - p0), 1);
      end
      checkOut("R2 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule